// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block turns the oscillator clock of an 8051-style core into the timing of its external memory bus. It divides each machine cycle into twelve clock periods, six states of two phases each, and drives three things from them. The first is a latch strobe that captures the low address byte. The second is an active-low read strobe for program memory. The third is the value placed on the high address byte. At the start of every machine cycle the core states what kind of bus cycle follows: internal, external code fetch, or external data read or write with an 8-bit or a 16-bit address. The block then shapes the strobes to match. In data cycles it drops one latch pulse and both program-read pulses.

A configuration bit can switch off the latch strobe so that it pulses only when external memory is actually used. When the strobe is switched off, the pin is released to a weak pull-up. While the core executes from external program memory, the disable bit has no effect. The block also qualifies the raw reset pin. It produces an internal reset only after the pin has stayed high for a programmable number of machine cycles, and it holds the sequencer at the first phase while that reset is active.

The state machine steps through the states ST_S1, ST_S2, ST_S3, ST_S4, ST_S5 and ST_S6. Within each state the phase bit moves from P1 to P2. The transition from P2 of a state goes to P1 of the next state, and P2 of ST_S6 wraps to P1 of ST_S1. That wrap is the cycle boundary, where the request is latched. The reset qualifier has an idle/counting condition and an asserted condition. A low sample on the pin moves it back to idle from either one. Reaching the full count moves it from counting to asserted.

Top module: `ebs_strobe_seq`

## Requirements
- R1: A machine cycle is 12 clock periods: the states ST_S1 to ST_S6 in order, each with phase P1 then P2. The inputs cyc_kind, ale_off, ext_exec, addr_hi_in and p2_sfr are sampled on the edge that leaves ST_S6/P2 and are held for the whole cycle that follows. The cyc_kind encoding is: 0 internal, 1 code fetch, 2 data read 8-bit, 3 data write 8-bit, 4 data read 16-bit, 5 data write 16-bit; 6 and 7 act as internal.
- R2: When the latch strobe is enabled, ale is high in ST_S1/P2, ST_S2/P1, ST_S4/P2 and ST_S5/P1 and low elsewhere. This gives one pulse every six clocks.
- R3: In a data cycle (kinds 2 to 5) the second latch pulse (ST_S4/P2, ST_S5/P1) is omitted and the first pulse is kept.
- R4: psen_n is low in ST_S2/P2 through ST_S3/P2 and in ST_S5/P2 through ST_S6/P2, and only in code-fetch cycles. It stays high in data and internal cycles and never overlaps an ale pulse.
- R5: With ale_off=1 and ext_exec=0, an internal cycle releases the latch pin: ale_drv=0 and ale=1. Code-fetch (table read) and data cycles still drive the pulses of R2 and R3 with ale_drv=1.
- R6: With ext_exec=1, ale_off has no effect and the latch strobe behaves as if enabled.
- R7: addr_hi carries the latched addr_hi_in in code-fetch and 16-bit data cycles, and the latched p2_sfr in 8-bit data cycles and internal cycles.
- R8: core_rst rises on the clock edge that samples rst_pin high for the RST_MCYC*12-th consecutive time (24 by default). An edge that samples rst_pin low clears the count and clears core_rst.
- R9: While core_rst is high, the sequencer is held at ST_S1/P1 with an internal cycle and the latch strobe enabled: ale=0, ale_drv=1, psen_n=1. On release it restarts from ST_S1/P1 with the disable bit treated as clear for that first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | Raw reset pin, active high |
| cyc_kind | input | 3 | Kind of the next machine cycle (encoding in R1) |
| ale_off | input | 1 | Latch-strobe disable configuration bit |
| ext_exec | input | 1 | Core is executing from external program memory |
| addr_hi_in | input | 8 | Address bits 15:8 of the coming access |
| p2_sfr | input | 8 | Port 2 latch contents |
| core_rst | output | 1 | Qualified internal reset |
| ale | output | 1 | Address latch strobe |
| ale_drv | output | 1 | 1 when ale is actively driven, 0 when released to the pull-up |
| psen_n | output | 1 | Program-store read strobe, active low |
| addr_hi | output | 8 | High address byte for the bus |

## Verification
The bench sweeps every cycle kind, including the two unused codes, against all four combinations of the disable bit and the external-execution flag. It compares every output in every one of the twelve phases. A design that kept the second latch pulse in data cycles, dropped the wrong one, or let the disable bit win during external execution would differ in a specific phase. The bench changes the live inputs just after the cycle boundary, so a design that passes addr_hi or the cycle kind through without latching gives the wrong high byte or the wrong strobes. For the reset qualifier, the bench checks the 23rd and 24th high samples, inserts a one-clock low glitch partway through a count, and checks the restart after release. An off-by-one counter, or one that does not restart on a glitch, asserts reset early or late.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

    localparam int STATES_PER_MC = 6;
    localparam int PHASES_PER_ST = 2;
    localparam int CLKS_PER_MC   = STATES_PER_MC * PHASES_PER_ST;

    typedef enum logic [2:0] {
        K_INT   = 3'd0,
        K_FETCH = 3'd1,
        K_RD8   = 3'd2,
        K_WR8   = 3'd3,
        K_RD16  = 3'd4,
        K_WR16  = 3'd5
    } kind_t;

    typedef enum logic [2:0] {
        ST_S1, ST_S2, ST_S3, ST_S4, ST_S5, ST_S6
    } mstate_t;

    function automatic kind_t decode_kind(input logic [2:0] raw);
        kind_t k;
        unique case (raw)
            3'd1:    k = K_FETCH;
            3'd2:    k = K_RD8;
            3'd3:    k = K_WR8;
            3'd4:    k = K_RD16;
            3'd5:    k = K_WR16;
            default: k = K_INT;
        endcase
        return k;
    endfunction

    function automatic logic is_data(input kind_t k);
        return (k == K_RD8) || (k == K_WR8) || (k == K_RD16) || (k == K_WR16);
    endfunction

    function automatic logic uses_wide(input kind_t k);
        return (k == K_FETCH) || (k == K_RD16) || (k == K_WR16);
    endfunction

endpackage

// File: rtl/ebs_rst_qual.sv
module ebs_rst_qual #(
    parameter int RST_MCYC = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic rst_pin,
    output logic core_rst
);
    localparam int LIMIT = RST_MCYC * ebs_pkg::CLKS_PER_MC;
    localparam int CW    = $clog2(LIMIT + 1);

    logic [CW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            hi_cnt   <= '0;
            core_rst <= 1'b0;
        end else if (!rst_pin) begin
            hi_cnt   <= '0;
            core_rst <= 1'b0;
        end else if (hi_cnt != CW'(LIMIT)) begin
            hi_cnt <= hi_cnt + 1'b1;
            if (hi_cnt == CW'(LIMIT - 1)) begin
                core_rst <= 1'b1;
            end
        end
    end

    // R8: a low sample always drops the reset on the next edge
    a_r8_low_clears: assert property (@(posedge clk) disable iff (!arst_n)
        !rst_pin |=> !core_rst);

    // R8: reset only rises after a high sample
    a_r8_rise_after_high: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(core_rst) |-> $past(rst_pin));

    // R8: reset active only with a full count behind it
    a_r8_full_count: assert property (@(posedge clk) disable iff (!arst_n)
        core_rst |-> (hi_cnt == CW'(LIMIT)));

endmodule

// File: rtl/ebs_phase_seq.sv
module ebs_phase_seq #(
    parameter int AW_HI = 8
) (
    input  logic                clk,
    input  logic                arst_n,
    input  logic                core_rst,
    input  logic [2:0]          cyc_kind,
    input  logic                ale_off,
    input  logic                ext_exec,
    input  logic [AW_HI-1:0]    addr_hi_in,
    input  logic [AW_HI-1:0]    p2_sfr,
    output ebs_pkg::mstate_t    st,
    output logic                ph,
    output ebs_pkg::kind_t      cur_kind,
    output logic                cur_ale_off,
    output logic                cur_xe,
    output logic [AW_HI-1:0]    cur_hi
);
    import ebs_pkg::*;

    mstate_t st_nx;
    logic    ph_nx;
    logic    boundary;
    kind_t   req_kind;

    assign boundary = (st == ST_S6) && ph;
    assign req_kind = decode_kind(cyc_kind);

    always_comb begin
        ph_nx = ~ph;
        st_nx = st;
        if (ph) begin
            unique case (st)
                ST_S1:   st_nx = ST_S2;
                ST_S2:   st_nx = ST_S3;
                ST_S3:   st_nx = ST_S4;
                ST_S4:   st_nx = ST_S5;
                ST_S5:   st_nx = ST_S6;
                ST_S6:   st_nx = ST_S1;
                default: st_nx = ST_S1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st <= ST_S1;
            ph <= 1'b0;
        end else if (core_rst) begin
            st <= ST_S1;
            ph <= 1'b0;
        end else begin
            st <= st_nx;
            ph <= ph_nx;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cur_kind    <= K_INT;
            cur_ale_off <= 1'b0;
            cur_xe      <= 1'b0;
            cur_hi      <= '0;
        end else if (core_rst) begin
            cur_kind    <= K_INT;
            cur_ale_off <= 1'b0;
            cur_xe      <= 1'b0;
            cur_hi      <= '0;
        end else if (boundary) begin
            cur_kind    <= req_kind;
            cur_ale_off <= ale_off;
            cur_xe      <= ext_exec;
            cur_hi      <= uses_wide(req_kind) ? addr_hi_in : p2_sfr;
        end
    end

    // R1: the latched cycle description only changes at the cycle boundary
    a_r1_hold_in_cycle: assert property (@(posedge clk) disable iff (!arst_n || core_rst)
        !boundary |=> $stable(cur_kind) && $stable(cur_hi) && $stable(cur_ale_off));

    // R1: P2 of ST_S6 wraps to P1 of ST_S1
    a_r1_wrap: assert property (@(posedge clk) disable iff (!arst_n || core_rst)
        boundary |=> (st == ST_S1) && !ph);

    // R9: held at the first phase while reset is active
    a_r9_hold_start: assert property (@(posedge clk) disable iff (!arst_n)
        core_rst |=> (st == ST_S1) && !ph && (cur_kind == K_INT) && !cur_ale_off);

endmodule

// File: rtl/ebs_strobe_gen.sv
module ebs_strobe_gen (
    input  ebs_pkg::mstate_t st,
    input  logic             ph,
    input  ebs_pkg::kind_t   cur_kind,
    input  logic             cur_ale_off,
    input  logic             cur_xe,
    output logic             ale,
    output logic             ale_drv,
    output logic             psen_n
);
    import ebs_pkg::*;

    logic slot_a;
    logic slot_b;
    logic slot_rd;
    logic ale_en;

    always_comb begin
        slot_a  = 1'b0;
        slot_b  = 1'b0;
        slot_rd = 1'b0;
        unique case (st)
            ST_S1: slot_a = ph;
            ST_S2: begin
                slot_a  = ~ph;
                slot_rd = ph;
            end
            ST_S3: slot_rd = 1'b1;
            ST_S4: slot_b = ph;
            ST_S5: begin
                slot_b  = ~ph;
                slot_rd = ph;
            end
            ST_S6: slot_rd = 1'b1;
            default: ;
        endcase
    end

    always_comb begin
        ale_en  = !cur_ale_off || cur_xe || (cur_kind != K_INT);
        ale_drv = ale_en;
        ale     = ale_en ? (slot_a || (slot_b && !is_data(cur_kind))) : 1'b1;
        psen_n  = !(slot_rd && (cur_kind == K_FETCH));
    end

    // R3: in data cycles the latch strobe is only high in the first half of the cycle
    a_r3_single_pulse: assert final (!(ale && ale_drv && is_data(cur_kind))
        || (st == ST_S1) || (st == ST_S2));

endmodule

// File: rtl/ebs_strobe_seq.sv
module ebs_strobe_seq #(
    parameter int RST_MCYC = 2,
    parameter int AW_HI    = 8
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             rst_pin,
    input  logic [2:0]       cyc_kind,
    input  logic             ale_off,
    input  logic             ext_exec,
    input  logic [AW_HI-1:0] addr_hi_in,
    input  logic [AW_HI-1:0] p2_sfr,
    output logic             core_rst,
    output logic             ale,
    output logic             ale_drv,
    output logic             psen_n,
    output logic [AW_HI-1:0] addr_hi
);
    import ebs_pkg::*;

    mstate_t          st;
    logic             ph;
    kind_t            cur_kind;
    logic             cur_ale_off;
    logic             cur_xe;
    logic [AW_HI-1:0] cur_hi;

    ebs_rst_qual #(.RST_MCYC(RST_MCYC)) u_rst_qual (
        .clk      (clk),
        .arst_n   (arst_n),
        .rst_pin  (rst_pin),
        .core_rst (core_rst)
    );

    ebs_phase_seq #(.AW_HI(AW_HI)) u_phase_seq (
        .clk         (clk),
        .arst_n      (arst_n),
        .core_rst    (core_rst),
        .cyc_kind    (cyc_kind),
        .ale_off     (ale_off),
        .ext_exec    (ext_exec),
        .addr_hi_in  (addr_hi_in),
        .p2_sfr      (p2_sfr),
        .st          (st),
        .ph          (ph),
        .cur_kind    (cur_kind),
        .cur_ale_off (cur_ale_off),
        .cur_xe      (cur_xe),
        .cur_hi      (cur_hi)
    );

    ebs_strobe_gen u_strobe_gen (
        .st          (st),
        .ph          (ph),
        .cur_kind    (cur_kind),
        .cur_ale_off (cur_ale_off),
        .cur_xe      (cur_xe),
        .ale         (ale),
        .ale_drv     (ale_drv),
        .psen_n      (psen_n)
    );

    assign addr_hi = cur_hi;

    // R4: read strobe and latch strobe never active together
    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!arst_n)
        !psen_n |-> !ale);

    // R5: a released latch pin reads high
    a_r5_release_high: assert property (@(posedge clk) disable iff (!arst_n)
        !ale_drv |-> ale);

    // R6: external execution always keeps the latch pin driven
    a_r6_xe_drives: assert property (@(posedge clk) disable iff (!arst_n)
        cur_xe |-> ale_drv);

    // R9: no read strobe during reset
    a_r9_quiet_in_reset: assert property (@(posedge clk) disable iff (!arst_n)
        core_rst |=> psen_n && ale_drv);

endmodule

// File: tb/ebs_strobe_seq_bench.sv
module ebs_strobe_seq_bench;

    logic       clk = 1'b0;
    logic       arst_n = 1'b0;
    logic       rst_pin = 1'b0;
    logic [2:0] cyc_kind = 3'd0;
    logic       ale_off = 1'b0;
    logic       ext_exec = 1'b0;
    logic [7:0] addr_hi_in = 8'h00;
    logic [7:0] p2_sfr = 8'h00;
    logic       core_rst;
    logic       ale;
    logic       ale_drv;
    logic       psen_n;
    logic [7:0] addr_hi;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ebs_strobe_seq u_ebs_strobe_seq (
        .clk        (clk),
        .arst_n     (arst_n),
        .rst_pin    (rst_pin),
        .cyc_kind   (cyc_kind),
        .ale_off    (ale_off),
        .ext_exec   (ext_exec),
        .addr_hi_in (addr_hi_in),
        .p2_sfr     (p2_sfr),
        .core_rst   (core_rst),
        .ale        (ale),
        .ale_drv    (ale_drv),
        .psen_n     (psen_n),
        .addr_hi    (addr_hi)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic bit data_k(input int k);
        return (k >= 2) && (k <= 5);
    endfunction

    function automatic bit exp_drv(input int k, input bit off, input bit xe);
        return !off || xe || (k == 1) || data_k(k);
    endfunction

    function automatic bit exp_ale(input int k, input bit off, input bit xe, input int g);
        if (!exp_drv(k, off, xe)) return 1'b1;
        if (g == 1 || g == 2) return 1'b1;
        if ((g == 7 || g == 8) && !data_k(k)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit exp_psen_n(input int k, input int g);
        if (k != 1) return 1'b1;
        return !(g == 3 || g == 4 || g == 5 || g == 9 || g == 10 || g == 11);
    endfunction

    task automatic check_phase(input int k, input bit off, input bit xe, input int g,
                               input logic [7:0] hi);
        string tag;
        tag = $sformatf("k%0d off%0d xe%0d g%0d", k, off, xe, g);
        if (xe && off)
            chk({7'd0, ale}, {7'd0, exp_ale(k, off, xe, g)}, {"R6 ale ", tag});
        else if (off && !xe)
            chk({7'd0, ale}, {7'd0, exp_ale(k, off, xe, g)}, {"R5 ale ", tag});
        else if (data_k(k))
            chk({7'd0, ale}, {7'd0, exp_ale(k, off, xe, g)}, {"R3 ale ", tag});
        else
            chk({7'd0, ale}, {7'd0, exp_ale(k, off, xe, g)}, {"R2 ale ", tag});
        chk({7'd0, ale_drv}, {7'd0, exp_drv(k, off, xe)}, {"R5 ale_drv ", tag});
        chk({7'd0, psen_n}, {7'd0, exp_psen_n(k, g)}, {"R4 psen_n ", tag});
        chk(addr_hi, hi, {"R7 addr_hi ", tag});
    endtask

    // Entered with the design in ST_S6/P2; leaves it there again.
    task automatic run_cycle(input int k, input bit off, input bit xe,
                             input logic [7:0] ah, input logic [7:0] p2);
        logic [7:0] hi;
        cyc_kind   = 3'(k);
        ale_off    = off;
        ext_exec   = xe;
        addr_hi_in = ah;
        p2_sfr     = p2;
        hi = (k == 1 || k == 4 || k == 5) ? ah : p2;
        tick();
        // R1: live inputs change after the boundary and must not leak through
        cyc_kind   = 3'(7 - k);
        ale_off    = !off;
        ext_exec   = !xe;
        addr_hi_in = ~ah;
        p2_sfr     = ~p2;
        for (int g = 0; g < 12; g++) begin
            check_phase(k, off, xe, g, hi);
            if (g < 11) tick();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        arst_n = 1'b1;
        // R9: reset state, first cycle internal and enabled
        chk({7'd0, core_rst}, 8'd0, "R9 core_rst after power-on");
        for (int g = 0; g < 11; g++) begin
            check_phase(0, 1'b0, 1'b0, g, 8'h00);
            if (g < 10) tick();
        end
        tick();

        // R1 R2 R3 R4 R5 R6 R7: sweep every kind against both configuration bits
        for (int k = 0; k < 8; k++) begin
            for (int c = 0; c < 4; c++) begin
                run_cycle(k, c[0], c[1], 8'(8'hA0 + k * 4 + c), 8'(8'h30 + k * 4 + c));
            end
        end

        // R8: 23 high samples do not reset, the 24th does
        rst_pin = 1'b1;
        for (int n = 1; n <= 24; n++) begin
            tick();
            if (n == 23) chk({7'd0, core_rst}, 8'd0, "R8 after 23 high samples");
            if (n == 24) chk({7'd0, core_rst}, 8'd1, "R8 after 24 high samples");
        end
        // R9: held quiet during reset even with disable requested
        ale_off = 1'b1;
        ext_exec = 1'b0;
        cyc_kind = 3'd1;
        for (int n = 0; n < 14; n++) begin
            tick();
            chk({7'd0, ale},     8'd0, "R9 ale in reset");
            chk({7'd0, ale_drv}, 8'd1, "R9 ale_drv in reset");
            chk({7'd0, psen_n},  8'd1, "R9 psen_n in reset");
        end

        // R8: a one-clock glitch drops reset and restarts the count
        rst_pin = 1'b0;
        tick();
        chk({7'd0, core_rst}, 8'd0, "R8 low sample clears");
        rst_pin = 1'b1;
        for (int n = 0; n < 20; n++) tick();
        rst_pin = 1'b0;
        tick();
        rst_pin = 1'b1;
        for (int n = 1; n <= 24; n++) begin
            tick();
            if (n == 23) chk({7'd0, core_rst}, 8'd0, "R8 glitch restarts count");
            if (n == 24) chk({7'd0, core_rst}, 8'd1, "R8 full count after glitch");
        end

        // R9: release restarts at ST_S1/P1 with the disable treated clear
        rst_pin = 1'b0;
        tick();
        chk({7'd0, core_rst}, 8'd0, "R9 released");
        chk({7'd0, ale},      8'd0, "R9 ale at restart S1P1");
        tick();
        chk({7'd0, ale},      8'd1, "R9 ale pulses in first cycle");
        chk({7'd0, ale_drv},  8'd1, "R9 disable cleared after reset");
        chk({7'd0, psen_n},   8'd1, "R9 no read strobe in internal cycle");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule